// File: doc/BRIEF.md
# Flash Power-Down and Abort Sequencer

This block controls the active-low reset/power-down pin of a NOR-flash-style memory model. The pin is brought into the clock domain through two flip-flops and must stay low for a minimum number of cycles before it has any effect. The block tracks whether an embedded program or erase is running. From that it decides whether a qualified low level sends an idle device into deep power-down, or aborts the running operation. An abort first passes through a fixed shutdown window.

On the way out of power-down, or at the end of a shutdown window whose pin is already high, the block enters a wake-up phase. In that phase it sends a one-cycle reset pulse to the command interface and a one-cycle preset of the status register. It then holds back the read-valid and write-allowed qualifiers for two separate recovery times. After an abort those times are counted from the end of the shutdown window, not from the rising edge of the pin. All intervals are parameters in clock cycles.

The states are PH_RUN (normal operation), PH_QUAL (pin low, qualifying the pulse), PH_SHUT (abort shutdown window), PH_DEEP (deep power-down) and PH_WAKE (recovery). The transitions are:
- RUN→QUAL on a low sample.
- QUAL→RUN on a high sample.
- QUAL→DEEP on a qualified low while idle.
- QUAL→SHUT on a qualified low while busy.
- SHUT→WAKE if the pin is high at the end of the window.
- SHUT→DEEP if the pin is still low at the end of the window.
- DEEP→WAKE on a high sample.
- WAKE→RUN when both recovery times have elapsed.
- WAKE→QUAL on a low sample.

Top module: `pwrdn_seq`

## Requirements
- R1: After `rst_n` is released the block is in normal operation: `rd_valid`=1, `wr_allowed`=1, `out_hiz`=0, `pd_active`=0, `busy`=0, `data_suspect`=0, and all strobes are 0.
- R2: The pin is synchronised by two flip-flops. A low level seen on fewer than MIN_PULSE consecutive synchronised samples changes no output.
- R3: MIN_PULSE consecutive low samples while no operation is busy enter deep power-down. There `pd_active`=1, `out_hiz`=1, and `rd_valid` and `wr_allowed` are both 0.
- R4: Entry to the wake-up phase raises `cmd_reset` and `sr_load` for exactly one cycle. `sr_value` carries 8'h80 in that cycle and 8'h00 otherwise.
- R5: `rd_valid` rises exactly RD_RECOV cycles after the `cmd_reset` cycle.
- R6: `wr_allowed` rises exactly WR_RECOV cycles after the `cmd_reset` cycle.
- R7: `op_start` sets `busy` only in normal operation while not busy. `op_done` clears `busy`. An `op_start` in any other phase is ignored.
- R8: A qualified low while busy produces a one-cycle `abort_strobe`. In the same cycle `busy` is cleared and `data_suspect` is set. `data_suspect` stays set until the next accepted `op_start`.
- R9: The shutdown window lasts SHUT_CYC cycles with `out_hiz`=1, starting with the `abort_strobe` cycle. If the pin is high at its last cycle, `cmd_reset` follows exactly SHUT_CYC cycles after `abort_strobe`. If the pin is still low, deep power-down follows.
- R10: A low sample during the wake-up phase restarts pulse qualification. MIN_PULSE consecutive lows lead back to deep power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| pd_pin_n | input | 1 | Asynchronous active-low reset/power-down pin |
| op_start | input | 1 | Program or erase begins (one-cycle pulse) |
| op_done | input | 1 | Program or erase completes (one-cycle pulse) |
| busy | output | 1 | Embedded operation in progress |
| data_suspect | output | 1 | Last operation was aborted; its word or block is invalid |
| abort_strobe | output | 1 | One-cycle abort event |
| rd_valid | output | 1 | Reads may be reported valid |
| wr_allowed | output | 1 | Writes may be accepted |
| out_hiz | output | 1 | Data outputs in high impedance |
| pd_active | output | 1 | Deep power-down phase |
| cmd_reset | output | 1 | One-cycle reset to the command interface (read-array mode) |
| sr_load | output | 1 | One-cycle status register preset strobe |
| sr_value | output | 8 | Preset value, valid with `sr_load` |

## Verification
Two functions can fall in the same cycle: the completion of a low-pulse qualification and the abort decision that depends on the busy flag. In that cycle the abort strobe, the busy clear and the suspect flag all change together. The bench starts an operation and holds the pin low until the pulse qualifies. A cycle-by-cycle behavioural model then judges `abort_strobe`, `busy` and `data_suspect` in that single cycle, and times the shutdown window and the recovery from the strobe. A second collision is a low sample arriving during wake-up, while the recovery counters are still running. The bench provokes it and expects qualification to restart rather than a return to normal operation.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;

    typedef enum logic [2:0] {
        PH_RUN,
        PH_QUAL,
        PH_SHUT,
        PH_DEEP,
        PH_WAKE
    } phase_e;

    localparam logic [7:0] SR_PRESET = 8'h80;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwrdn_sync2.sv
module pwrdn_sync2 #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic stage1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RESET_VAL;
            q_sync   <= RESET_VAL;
        end else begin
            stage1_q <= d_async;
            q_sync   <= stage1_q;
        end
    end
endmodule

// File: rtl/pwrdn_timer.sv
module pwrdn_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (clr)            cnt <= '0;
        else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwrdn_busy.sv
module pwrdn_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic done,
    input  logic abort,
    output logic busy,
    output logic suspect
);
    logic start_ok;

    assign start_ok = start_req && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            suspect <= 1'b0;
        end else begin
            if (abort)         busy <= 1'b0;
            else if (start_ok) busy <= 1'b1;
            else if (done)     busy <= 1'b0;

            if (abort)         suspect <= 1'b1;
            else if (start_ok) suspect <= 1'b0;
        end
    end
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
    import pwrdn_seq_pkg::*;
#(
    parameter int MIN_PULSE = 8,
    parameter int SHUT_CYC  = 16,
    parameter int RD_RECOV  = 10,
    parameter int WR_RECOV  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_pin_n,
    input  logic       op_start,
    input  logic       op_done,
    output logic       busy,
    output logic       data_suspect,
    output logic       abort_strobe,
    output logic       rd_valid,
    output logic       wr_allowed,
    output logic       out_hiz,
    output logic       pd_active,
    output logic       cmd_reset,
    output logic       sr_load,
    output logic [7:0] sr_value
);
    localparam int WAKE_LEN = max2(RD_RECOV, WR_RECOV);
    localparam int TMAX     = max2(max2(MIN_PULSE, SHUT_CYC), WAKE_LEN);
    localparam int CW       = $clog2(TMAX + 2);

    localparam logic [CW-1:0] QUAL_LAST = CW'(MIN_PULSE - 2);
    localparam logic [CW-1:0] SHUT_LAST = CW'(SHUT_CYC - 1);
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_LEN - 1);
    localparam logic [CW-1:0] RD_LIM    = CW'(RD_RECOV);
    localparam logic [CW-1:0] WR_LIM    = CW'(WR_RECOV);

    phase_e        state_q, state_d;
    logic          pin_s;
    logic [CW-1:0] cnt;
    logic          abort_take;
    logic          phase_change;

    pwrdn_sync2 #(.RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pd_pin_n),
        .q_sync  (pin_s)
    );

    assign phase_change = (state_d != state_q);

    pwrdn_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_change),
        .cnt   (cnt)
    );

    pwrdn_busy u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (op_start && (state_q == PH_RUN)),
        .done      (op_done),
        .abort     (abort_take),
        .busy      (busy),
        .suspect   (data_suspect)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_RUN;
        else        state_q <= state_d;
    end

    // next phase
    always_comb begin
        state_d    = state_q;
        abort_take = 1'b0;
        unique case (state_q)
            PH_RUN: begin
                if (!pin_s) state_d = PH_QUAL;
            end
            PH_QUAL: begin
                if (pin_s) begin
                    state_d = PH_RUN;
                end else if (cnt == QUAL_LAST) begin
                    if (busy) begin
                        state_d    = PH_SHUT;
                        abort_take = 1'b1;
                    end else begin
                        state_d = PH_DEEP;
                    end
                end
            end
            PH_SHUT: begin
                if (cnt == SHUT_LAST) state_d = pin_s ? PH_WAKE : PH_DEEP;
            end
            PH_DEEP: begin
                if (pin_s) state_d = PH_WAKE;
            end
            PH_WAKE: begin
                if (!pin_s)                state_d = PH_QUAL;
                else if (cnt == WAKE_LAST) state_d = PH_RUN;
            end
            default: state_d = PH_RUN;
        endcase
    end

    // outputs
    always_comb begin
        rd_valid     = 1'b0;
        wr_allowed   = 1'b0;
        out_hiz      = 1'b0;
        pd_active    = 1'b0;
        cmd_reset    = 1'b0;
        abort_strobe = 1'b0;
        unique case (state_q)
            PH_RUN, PH_QUAL: begin
                rd_valid   = 1'b1;
                wr_allowed = 1'b1;
            end
            PH_SHUT: begin
                out_hiz      = 1'b1;
                abort_strobe = (cnt == '0);
            end
            PH_DEEP: begin
                out_hiz   = 1'b1;
                pd_active = 1'b1;
            end
            PH_WAKE: begin
                rd_valid   = (cnt >= RD_LIM);
                wr_allowed = (cnt >= WR_LIM);
                cmd_reset  = (cnt == '0);
            end
            default: begin
                out_hiz = 1'b1;
            end
        endcase
        sr_load  = cmd_reset;
        sr_value = cmd_reset ? SR_PRESET : 8'h00;
    end

endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_start,
    input logic       busy,
    input logic       data_suspect,
    input logic       abort_strobe,
    input logic       rd_valid,
    input logic       wr_allowed,
    input logic       out_hiz,
    input logic       pd_active,
    input logic       cmd_reset,
    input logic       sr_load,
    input logic [7:0] sr_value
);
    a_r3_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> (out_hiz && !rd_valid && !wr_allowed));

    a_r4_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> !cmd_reset);

    a_r4_preset_val: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load |-> (sr_value == 8'h80));

    a_r4_preset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_load |-> (sr_value == 8'h00));

    a_r4_wake_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |-> (!pd_active && !out_hiz));

    a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(op_start));

    a_r8_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        abort_strobe |=> !abort_strobe);

    a_r8_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
        abort_strobe |-> (!busy && data_suspect && $past(busy)));

    a_r9_shut_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        abort_strobe |-> (out_hiz && !rd_valid && !wr_allowed && !pd_active));
endmodule

bind pwrdn_seq pwrdn_seq_chk u_pwrdn_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_start     (op_start),
    .busy         (busy),
    .data_suspect (data_suspect),
    .abort_strobe (abort_strobe),
    .rd_valid     (rd_valid),
    .wr_allowed   (wr_allowed),
    .out_hiz      (out_hiz),
    .pd_active    (pd_active),
    .cmd_reset    (cmd_reset),
    .sr_load      (sr_load),
    .sr_value     (sr_value)
);

// File: tb/pwrdn_seq_bench.sv
`timescale 1ns/1ps
module pwrdn_seq_bench;
    localparam int MINP = 4;
    localparam int SHUT = 6;
    localparam int RDR  = 3;
    localparam int WRR  = 5;
    localparam int WLEN = (RDR > WRR) ? RDR : WRR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_pin_n = 1'b1;
    logic op_start = 1'b0;
    logic op_done = 1'b0;
    logic busy, data_suspect, abort_strobe, rd_valid, wr_allowed;
    logic out_hiz, pd_active, cmd_reset, sr_load;
    logic [7:0] sr_value;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwrdn_seq #(.MIN_PULSE(MINP), .SHUT_CYC(SHUT), .RD_RECOV(RDR), .WR_RECOV(WRR)) u_pwrdn_seq (
        .clk(clk), .rst_n(rst_n), .pd_pin_n(pd_pin_n), .op_start(op_start), .op_done(op_done),
        .busy(busy), .data_suspect(data_suspect), .abort_strobe(abort_strobe),
        .rd_valid(rd_valid), .wr_allowed(wr_allowed), .out_hiz(out_hiz), .pd_active(pd_active),
        .cmd_reset(cmd_reset), .sr_load(sr_load), .sr_value(sr_value)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    // modes: 0 normal, 1 qualifying, 2 shutdown, 3 power-down, 4 recovery
    int  m_mode = 0;
    int  m_lows = 0;
    int  m_t = 0;
    bit  m_busy = 0, m_susp = 0;
    bit  m_s1 = 1, m_s2 = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_lows = 0; m_t = 0; m_busy = 0; m_susp = 0; m_s1 = 1; m_s2 = 1;
        end else begin
            automatic bit seen  = m_s2;
            automatic bit abort = 0;
            automatic bit st_ok = (m_mode == 0) && op_start && !m_busy;
            m_s2 = m_s1;
            m_s1 = pd_pin_n;
            case (m_mode)
                0: if (!seen) begin m_mode = 1; m_lows = 1; end
                1: if (seen) m_mode = 0;
                   else begin
                       m_lows++;
                       if (m_lows == MINP) begin
                           if (m_busy) begin m_mode = 2; m_t = 0; abort = 1; end
                           else m_mode = 3;
                       end
                   end
                2: if (m_t == SHUT - 1) begin
                       if (seen) begin m_mode = 4; m_t = 0; end else m_mode = 3;
                   end else m_t++;
                3: if (seen) begin m_mode = 4; m_t = 0; end
                4: if (!seen) begin m_mode = 1; m_lows = 1; end
                   else if (m_t == WLEN - 1) m_mode = 0;
                   else m_t++;
                default: m_mode = 0;
            endcase
            if (abort) begin m_busy = 0; m_susp = 1; end
            else if (st_ok) begin m_busy = 1; m_susp = 0; end
            else if (op_done) m_busy = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit e_norm = (m_mode == 0) || (m_mode == 1);
            automatic bit e_rd   = e_norm || (m_mode == 4 && m_t >= RDR);
            automatic bit e_wr   = e_norm || (m_mode == 4 && m_t >= WRR);
            automatic bit e_cr   = (m_mode == 4) && (m_t == 0);
            check("R5 rd_valid", rd_valid, e_rd);
            check("R6 wr_allowed", wr_allowed, e_wr);
            check("R3 out_hiz", out_hiz, (m_mode == 2) || (m_mode == 3));
            check("R3 pd_active", pd_active, m_mode == 3);
            check("R4 cmd_reset", cmd_reset, e_cr);
            check("R4 sr_load", sr_load, e_cr);
            check("R4 sr_value", sr_value, e_cr ? 8'h80 : 8'h00);
            check("R8 abort_strobe", abort_strobe, (m_mode == 2) && (m_t == 0));
            check("R7 busy", busy, m_busy);
            check("R8 data_suspect", data_suspect, m_susp);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        op_start = 1'b1; cyc(1); op_start = 1'b0;
    endtask

    // waits for cmd_reset, then measures read and write recovery (R5, R6)
    task automatic measure_recovery(input string tag);
        automatic int rd_at = -1;
        automatic int wr_at = -1;
        for (int i = 0; i < 40 && !cmd_reset; i++) cyc(1);
        check({tag, " R4 cmd_reset seen"}, cmd_reset, 1);
        check({tag, " R4 preset 0x80"}, sr_value, 8'h80);
        for (int i = 1; i <= 20; i++) begin
            cyc(1);
            if (rd_valid && rd_at < 0) rd_at = i;
            if (wr_allowed && wr_at < 0) wr_at = i;
        end
        check({tag, " R5 read recovery"}, rd_at, RDR);
        check({tag, " R6 write recovery"}, wr_at, WRR);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1 rd_valid", rd_valid, 1);
        check("R1 wr_allowed", wr_allowed, 1);
        check("R1 out_hiz", out_hiz, 0);
        check("R1 pd_active", pd_active, 0);
        check("R1 busy", busy, 0);
        check("R1 data_suspect", data_suspect, 0);

        // R2 short low pulse is ignored
        begin
            automatic bit moved = 0;
            pd_pin_n = 1'b0; cyc(MINP - 1); pd_pin_n = 1'b1;
            for (int i = 0; i < 10; i++) begin
                cyc(1);
                if (pd_active || out_hiz || !rd_valid || !wr_allowed) moved = 1;
            end
            check("R2 short pulse no effect", moved, 0);
        end

        // R3 idle power-down, R4/R5/R6 wake-up
        pd_pin_n = 1'b0; cyc(MINP + 4);
        check("R3 power-down entered", pd_active, 1);
        check("R3 outputs hiz", out_hiz, 1);
        pd_pin_n = 1'b1;
        measure_recovery("wake");

        // R7 operation tracking
        pulse_start();
        check("R7 busy set", busy, 1);
        pulse_start();
        check("R7 start while busy keeps busy", busy, 1);
        op_done = 1'b1; cyc(1); op_done = 1'b0;
        check("R7 done clears busy", busy, 0);

        // R8/R9 abort with pin released during window
        pulse_start();
        pd_pin_n = 1'b0;
        for (int i = 0; i < 30 && !abort_strobe; i++) cyc(1);
        check("R8 abort strobe", abort_strobe, 1);
        check("R8 busy cleared with abort", busy, 0);
        check("R8 suspect set", data_suspect, 1);
        pd_pin_n = 1'b1;
        begin
            automatic int gap = -1;
            for (int i = 1; i <= 20 && gap < 0; i++) begin
                cyc(1);
                if (cmd_reset) gap = i;
            end
            check("R9 window length to wake", gap, SHUT);
            begin
                automatic int rd_at = -1;
                for (int i = 1; i <= 20; i++) begin
                    cyc(1);
                    if (rd_valid && rd_at < 0) rd_at = i;
                end
                check("R9 read recovery from window end", rd_at, RDR);
            end
        end
        pulse_start();
        check("R8 suspect cleared by new start", data_suspect, 0);

        // R9 abort with pin held low: power-down after window
        pd_pin_n = 1'b0;
        for (int i = 0; i < 30 && !abort_strobe; i++) cyc(1);
        check("R9 abort while held", abort_strobe, 1);
        cyc(SHUT + 2);
        check("R9 power-down after window", pd_active, 1);
        // R7 start ignored in power-down
        pulse_start();
        check("R7 start ignored in power-down", busy, 0);

        // R10 low during recovery restarts qualification
        pd_pin_n = 1'b1;
        for (int i = 0; i < 30 && !cmd_reset; i++) cyc(1);
        pd_pin_n = 1'b0;
        cyc(2);
        check("R10 still recovering", pd_active, 0);
        cyc(MINP + 3);
        check("R10 back to power-down", pd_active, 1);
        pd_pin_n = 1'b1;
        measure_recovery("rewake");
        cyc(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule